// File: doc/BRIEF.md
# Dual-Tone Function Generator

This block is a per-core function generator that feeds one pin DAC. It has two independent channels. Each channel owns a 32-bit phase accumulator that advances by a programmable frequency word, and it turns the top bits of that phase into a signed sample. The sample can be a sine, a triangle, a sawtooth or a square wave. A 9-bit amplitude coefficient then scales it. The scaled outputs of the two channels are added and clamped into one 18-bit code. A pair of tones, such as a dual-tone dialling pair, therefore leaves the pin with no software help once the channels are set up.

The converter in the pad has only 9 bits. A first-order error-feedback stage reduces the 18-bit code to a 9-bit offset-binary word. It carries the 9 discarded low bits from clock to clock, so the long-run average of the 9-bit word matches the full code. The channel enables gate both phase advance and output. The amplitude and waveform select of each channel may change at any time, and the change takes effect at the pipeline stage that uses it.

Top module: `dual_tone_gen`

## Requirements
- R1: While reset is asserted and directly after it, both phases are zero, `code_o` is 0 and `dac_o` is 256 (midscale).
- R2: On each clock edge with its enable high, a channel's phase grows by its frequency word modulo 2^32. With the enable low, the phase holds and the channel's sample is forced to 0. The waveform index is phase bits [31:23].
- R3: Waveform select 3 (square) gives +255 while index bit 8 is 0, and -255 otherwise.
- R4: Waveform select 2 (sawtooth) gives the index minus 256, a range of -256 to +255.
- R5: Waveform select 1 (triangle) gives 2*f - 255, where f is the index when it is below 256 and 511 minus the index otherwise.
- R6: Waveform select 0 (sine) gives round(255*sin(2*pi*(index+0.5)/512)), with halves rounded away from zero. It is built from a 128-entry quarter-wave table mirrored by index bits 8 and 7.
- R7: A channel's contribution is its sample times its unsigned 9-bit amplitude (0 to 511). An amplitude of 0 silences the channel.
- R8: `code_o` is the sum of both contributions, clamped to the range -131072 to +131071.
- R9: The sample stage registers the sample, using the phase, enable and select in force before that edge. The next edge registers the product, using the amplitude present at that edge. The edge after that registers `code_o`.
- R10: `dac_o` is registered one clock after `code_o` and is based on the offset code u = `code_o` + 131072. It equals u[17:9] plus the carry out of a 9-bit accumulator that adds u[8:0] every clock. For a constant code, any 512 consecutive `dac_o` values sum exactly to u.
- R11: When u[17:9] is 511 and a carry occurs, `dac_o` stays at 511 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 2 | Enable, bit 0 for channel A and bit 1 for channel B |
| freq_a_i | input | 32 | Channel A phase increment per clock |
| freq_b_i | input | 32 | Channel B phase increment per clock |
| wave_a_i | input | 2 | Channel A waveform: 0 sine, 1 triangle, 2 sawtooth, 3 square |
| wave_b_i | input | 2 | Channel B waveform, same encoding |
| amp_a_i | input | 9 | Channel A amplitude coefficient |
| amp_b_i | input | 9 | Channel B amplitude coefficient |
| code_o | output | 18 | Clamped signed sum of both channels |
| dac_o | output | 9 | Dithered offset-binary converter word |

## Verification
`code_o` reflects the phase, enable and select that were in force three edges earlier, the amplitude from two edges earlier, and nothing newer. `dac_o` follows one edge after the code that produced it. The bench changes inputs only on falling edges. It advances a register-for-register expectation of those stages on each rising edge and compares both outputs on the following falling edge. Every expectation is therefore tied to the exact cycle in which its inputs were present, including the cycles around enable and amplitude changes. The 512-cycle dither sum and the clamp checks hold the configuration steady long enough that the pipeline is full before any sample is taken.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_TRI    = 2'd1,
        WAVE_SAW    = 2'd2,
        WAVE_SQUARE = 2'd3
    } wave_e;

    localparam real PI_R = 3.14159265358979323846;

    // Quarter-wave magnitude at the centre of slot idx, rounded to nearest.
    function automatic int quarter_sine(int idx, int depth, int peak);
        real ang;
        ang = PI_R * real'(2 * idx + 1) / (4.0 * real'(depth));
        return $rtoi(real'(peak) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/tone_shaper.sv
module tone_shaper
    import tone_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic [IDX_W-1:0]        idx_i,
    input  wave_e                   sel_i,
    output logic signed [IDX_W-1:0] sample_o
);
    localparam int QDEPTH = 2 ** (IDX_W - 2);
    localparam int PEAK   = 2 ** (IDX_W - 1) - 1;
    localparam logic signed [IDX_W-1:0] PEAK_S = IDX_W'(PEAK);

    logic [IDX_W-2:0] rom [QDEPTH];

    for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_rom
        localparam int QV = quarter_sine(gi, QDEPTH, PEAK);
        assign rom[gi] = QV[IDX_W-2:0];
    end

    logic                   half_w;
    logic                   quart_w;
    logic [IDX_W-3:0]       qaddr_w;
    logic [IDX_W-2:0]       mag_w;
    logic [IDX_W-2:0]       fold_w;
    logic signed [IDX_W:0]  tri_w;
    logic signed [IDX_W-1:0] sine_w;
    logic signed [IDX_W-1:0] saw_w;

    assign half_w  = idx_i[IDX_W-1];
    assign quart_w = idx_i[IDX_W-2];
    // second and fourth quarters read the table backwards
    assign qaddr_w = quart_w ? ~idx_i[IDX_W-3:0] : idx_i[IDX_W-3:0];
    assign mag_w   = rom[qaddr_w];
    assign sine_w  = half_w ? -$signed({1'b0, mag_w}) : $signed({1'b0, mag_w});

    assign fold_w  = half_w ? ~idx_i[IDX_W-2:0] : idx_i[IDX_W-2:0];
    assign tri_w   = $signed({1'b0, fold_w, 1'b0}) - $signed((IDX_W+1)'(PEAK));

    assign saw_w   = $signed({~idx_i[IDX_W-1], idx_i[IDX_W-2:0]});

    always_comb begin
        unique case (sel_i)
            WAVE_SINE:   sample_o = sine_w;
            WAVE_TRI:    sample_o = tri_w[IDX_W-1:0];
            WAVE_SAW:    sample_o = saw_w;
            WAVE_SQUARE: sample_o = half_w ? -PEAK_S : PEAK_S;
            default:     sample_o = '0;
        endcase
    end

endmodule

// File: rtl/tone_channel.sv
module tone_channel
    import tone_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int IDX_W   = 9,
    parameter int AMP_W   = 9
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            en_i,
    input  logic [PHASE_W-1:0]              freq_i,
    input  logic [1:0]                      sel_i,
    input  logic [AMP_W-1:0]                amp_i,
    output logic signed [IDX_W+AMP_W-1:0]   prod_o
);
    localparam int PROD_W = IDX_W + AMP_W;
    localparam logic signed [IDX_W-1:0] PEAK_S = IDX_W'(2 ** (IDX_W - 1) - 1);

    logic [PHASE_W-1:0]      phase_q;
    logic signed [IDX_W-1:0] sample_q;
    logic signed [IDX_W-1:0] shape_w;
    logic signed [PROD_W:0]  mult_w;
    logic signed [PROD_W-1:0] prod_q;
    wave_e                   sel_w;

    assign sel_w = wave_e'(sel_i);

    tone_shaper #(.IDX_W(IDX_W)) u_shaper (
        .idx_i    (phase_q[PHASE_W-1 -: IDX_W]),
        .sel_i    (sel_w),
        .sample_o (shape_w)
    );

    assign mult_w = sample_q * $signed({1'b0, amp_i});

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q  <= '0;
            sample_q <= '0;
            prod_q   <= '0;
        end else begin
            if (en_i) begin
                phase_q  <= phase_q + freq_i;
                sample_q <= shape_w;
            end else begin
                sample_q <= '0;
            end
            prod_q <= mult_w[PROD_W-1:0];
        end
    end

    assign prod_o = prod_q;

    // R2
    phase_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> phase_q == $past(phase_q) + $past(freq_i));

    // R2
    phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (phase_q == $past(phase_q)) && (sample_q == '0));

    // R3
    square_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && sel_w == WAVE_SQUARE) |=> (sample_q == PEAK_S || sample_q == -PEAK_S));

    // R7
    zero_amp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (amp_i == '0) |=> prod_q == '0);

endmodule

// File: rtl/tone_dither.sv
module tone_dither #(
    parameter int CODE_W = 18,
    parameter int DAC_W  = 9
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic signed [CODE_W-1:0] code_i,
    output logic [DAC_W-1:0]         dac_o
);
    localparam int FRAC_W = CODE_W - DAC_W;
    localparam logic [DAC_W-1:0] MID = DAC_W'(2 ** (DAC_W - 1));

    logic [CODE_W-1:0] offs_w;
    logic [DAC_W-1:0]  top_w;
    logic [FRAC_W:0]   acc_w;
    logic              carry_w;
    logic [FRAC_W-1:0] err_q;
    logic [DAC_W-1:0]  dac_q;

    assign offs_w  = {~code_i[CODE_W-1], code_i[CODE_W-2:0]};
    assign top_w   = offs_w[CODE_W-1 -: DAC_W];
    assign acc_w   = {1'b0, err_q} + {1'b0, offs_w[FRAC_W-1:0]};
    assign carry_w = acc_w[FRAC_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= '0;
            dac_q <= MID;
        end else begin
            err_q <= acc_w[FRAC_W-1:0];
            if (carry_w && (&top_w)) dac_q <= top_w;
            else                     dac_q <= top_w + DAC_W'(carry_w);
        end
    end

    assign dac_o = dac_q;

    // R10
    dac_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dac_q == $past(top_w)) || (dac_q == $past(top_w) + DAC_W'(1)));

endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen #(
    parameter int PHASE_W = 32,
    parameter int IDX_W   = 9,
    parameter int AMP_W   = 9,
    parameter int DAC_W   = 9
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [1:0]                       chan_en_i,
    input  logic [PHASE_W-1:0]               freq_a_i,
    input  logic [PHASE_W-1:0]               freq_b_i,
    input  logic [1:0]                       wave_a_i,
    input  logic [1:0]                       wave_b_i,
    input  logic [AMP_W-1:0]                 amp_a_i,
    input  logic [AMP_W-1:0]                 amp_b_i,
    output logic signed [IDX_W+AMP_W-1:0]    code_o,
    output logic [DAC_W-1:0]                 dac_o
);
    localparam int NCH    = 2;
    localparam int CODE_W = IDX_W + AMP_W;
    localparam logic signed [CODE_W:0] MAX_C = (CODE_W+1)'(2 ** (CODE_W - 1) - 1);
    localparam logic signed [CODE_W:0] MIN_C = -(CODE_W+1)'(2 ** (CODE_W - 1));

    logic [PHASE_W-1:0]       freq_w [NCH];
    logic [1:0]               sel_w  [NCH];
    logic [AMP_W-1:0]         amp_w  [NCH];
    logic signed [CODE_W-1:0] prod_w [NCH];
    logic signed [CODE_W:0]   total_w;
    logic signed [CODE_W-1:0] clamp_w;
    logic signed [CODE_W-1:0] code_q;

    assign freq_w[0] = freq_a_i;
    assign freq_w[1] = freq_b_i;
    assign sel_w[0]  = wave_a_i;
    assign sel_w[1]  = wave_b_i;
    assign amp_w[0]  = amp_a_i;
    assign amp_w[1]  = amp_b_i;

    for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
        tone_channel #(
            .PHASE_W (PHASE_W),
            .IDX_W   (IDX_W),
            .AMP_W   (AMP_W)
        ) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (chan_en_i[gc]),
            .freq_i (freq_w[gc]),
            .sel_i  (sel_w[gc]),
            .amp_i  (amp_w[gc]),
            .prod_o (prod_w[gc])
        );
    end

    always_comb begin
        total_w = '0;
        for (int c = 0; c < NCH; c++) total_w = total_w + (CODE_W+1)'(prod_w[c]);
        if (total_w > MAX_C)      clamp_w = MAX_C[CODE_W-1:0];
        else if (total_w < MIN_C) clamp_w = MIN_C[CODE_W-1:0];
        else                      clamp_w = total_w[CODE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) code_q <= '0;
        else         code_q <= clamp_w;
    end

    tone_dither #(.CODE_W(CODE_W), .DAC_W(DAC_W)) u_dither (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (code_q),
        .dac_o  (dac_o)
    );

    assign code_o = code_q;

    // R8
    pos_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prod_w[0][CODE_W-1] && !prod_w[1][CODE_W-1]) |=> !code_q[CODE_W-1]);

    // R8
    neg_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prod_w[0][CODE_W-1] && prod_w[1][CODE_W-1]) |=> code_q[CODE_W-1]);

endmodule

// File: tb/dual_tone_gen_bench.sv
module dual_tone_gen_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        en = 2'b00;
    logic [31:0]       fa = '0, fb = '0;
    logic [1:0]        wa = '0, wb = '0;
    logic [8:0]        aa = '0, ab = '0;
    logic signed [17:0] code_o;
    logic [8:0]        dac_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expectation registers, one per pipeline stage in R9 / R10
    logic [31:0] m_ph [2];
    int m_samp [2];
    int m_prod [2];
    int m_code, m_dac, m_err;

    always #4 clk = ~clk;

    dual_tone_gen u_dual_tone_gen (
        .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en),
        .freq_a_i(fa), .freq_b_i(fb), .wave_a_i(wa), .wave_b_i(wb),
        .amp_a_i(aa), .amp_b_i(ab), .code_o(code_o), .dac_o(dac_o)
    );

    function automatic int wave_ref(int sel, int p);
        real r;
        int  f;
        case (sel)
            0: begin // R6
                r = 255.0 * $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 512.0);
                if (r >= 0.0) return $rtoi($floor(r + 0.5));
                else          return -$rtoi($floor(-r + 0.5));
            end
            1: begin // R5
                f = (p < 256) ? p : 511 - p;
                return 2 * f - 255;
            end
            2: return p - 256;                  // R4
            default: return (p < 256) ? 255 : -255; // R3
        endcase
    endfunction

    function automatic int clamp_ref(int v); // R8
        if (v > 131071)  return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_ph[c] = '0; m_samp[c] = 0; m_prod[c] = 0;
        end
        m_code = 0; m_dac = 256; m_err = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        check("R1 code", int'(code_o), 0);
        check("R1 dac", int'(dac_o), 256);
        rst_n = 1'b1;
    endtask

    // one clock: advance the expectation, compare on the falling edge
    task automatic tick(input bit chk);
        int u, top, s, carry, tot;
        int sel [2];
        int amp [2];
        logic [31:0] frq [2];
        sel[0] = int'(wa); sel[1] = int'(wb);
        amp[0] = int'(aa); amp[1] = int'(ab);
        frq[0] = fa; frq[1] = fb;
        @(posedge clk);
        // R10 / R11: converter word from the previous code
        u = m_code + 131072;
        top = u >>> 9;
        s = m_err + (u & 511);
        carry = s >>> 9;
        m_err = s & 511;
        m_dac = (carry == 1 && top == 511) ? 511 : top + carry;
        // R8
        tot = m_prod[0] + m_prod[1];
        m_code = clamp_ref(tot);
        for (int c = 0; c < 2; c++) begin
            m_prod[c] = m_samp[c] * amp[c];                        // R7
            m_samp[c] = en[c] ? wave_ref(sel[c], int'(m_ph[c][31:23])) : 0;
            if (en[c]) m_ph[c] = m_ph[c] + frq[c];                  // R2
        end
        @(negedge clk);
        if (chk) begin
            check("R9 code", int'(code_o), m_code);
            check("R10 dac", int'(dac_o), m_dac);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sum;
        int amps [2];
        amps[0] = 511; amps[1] = 77;

        // R1 reset state
        do_reset();

        // single-channel sweeps of every index for every waveform: R3 R4 R5 R6
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 2; k++) begin
                en = 2'b00; fa = 32'h0080_0000; wa = 2'(w); aa = 9'(amps[k]);
                do_reset();
                en = 2'b01;
                for (int t = 0; t < 520; t++) tick(1'b1);
            end
        end

        // two channels summed, with enable and amplitude changes: R2 R7 R8
        en = 2'b00;
        do_reset();
        fa = 32'h0080_0000; wa = 2'd0; aa = 9'd300;
        fb = 32'h0180_3039; wb = 2'd1; ab = 9'd200;
        en = 2'b11;
        for (int t = 0; t < 300; t++) tick(1'b1);
        en = 2'b01;                                 // R2 channel B held
        for (int t = 0; t < 40; t++) tick(1'b1);
        en = 2'b11;
        aa = 9'd0;                                  // R7 channel A silenced
        for (int t = 0; t < 40; t++) tick(1'b1);
        aa = 9'd450; ab = 9'd511; wa = 2'd3; wb = 2'd3; // R8 clamping hit
        for (int t = 0; t < 400; t++) tick(1'b1);

        // phase wrap downwards: R2
        en = 2'b00;
        do_reset();
        fa = 32'hFF80_0000; wa = 2'd0; aa = 9'd511;
        fb = 32'h0000_0000; ab = 9'd0;
        en = 2'b01;
        for (int t = 0; t < 600; t++) tick(1'b1);

        // positive clamp with constant code: R8 R11
        en = 2'b00;
        do_reset();
        fa = '0; fb = '0; wa = 2'd3; wb = 2'd3; aa = 9'd511; ab = 9'd511;
        en = 2'b11;
        for (int t = 0; t < 12; t++) tick(1'b1);
        check("R8 positive clamp", int'(code_o), 131071);
        check("R11 dac ceiling", int'(dac_o), 511);

        // negative clamp: sawtooth at index 0 is -256: R4 R8
        en = 2'b00;
        do_reset();
        wa = 2'd2; wb = 2'd2;
        en = 2'b11;
        for (int t = 0; t < 12; t++) tick(1'b1);
        check("R8 negative clamp", int'(code_o), -131072);
        check("R10 dac floor", int'(dac_o), 0);

        // dither mean over 512 clocks: code 765, u = 131837
        en = 2'b00;
        do_reset();
        wa = 2'd3; aa = 9'd3; ab = 9'd0;
        en = 2'b01;
        for (int t = 0; t < 8; t++) tick(1'b1);
        sum = 0;
        for (int t = 0; t < 512; t++) begin
            tick(1'b1);
            sum += int'(dac_o);
        end
        check("R10 dither mean", sum, 131837);

        finish_run();
    end

endmodule